// File: doc/BRIEF.md
# Bus Termination Hold-Off Controller

This block sits in the bus interface of a processor. For each data beat it keeps the slave termination inputs (acknowledge, error, retry) masked for a programmed number of bus clocks. This lets a system with a fast bus clock give slow slaves extra time without timing every termination path to one clock.

The hold-off counts come from the data bus while reset is asserted. Four 4-bit fields are captured there: one pair for reads and one pair for writes. In each pair, the first-beat count governs a single transfer or the opening long word of a line. The follow-on count governs the three later long words of a line. A separate enable input, also captured during reset, turns the feature on. When it is off, every count behaves as zero.

The bus-cycle sequencer starts a cycle with a one-clock `start` pulse that carries a direction flag and a line flag. The controller then reports three things back to the sequencer: the clock on which sampling opens, each acknowledged beat, and the end of the cycle with its outcome.

Top module: `ack_holdoff_ctl`

## Requirements
- R1: The controller captures the data bus on the last clock with `rst` high. The field mapping is: read first-beat count from bits 15:12, read follow-on count from bits 11:8, write first-beat count from bits 7:4, and write follow-on count from bits 3:0. Changes on `cfg_bus` after reset have no effect.
- R2: `cfg_en` is captured on the same clock as the data bus. If it was low, every count is treated as zero until the next reset.
- R3: A single transfer, and beat 1 of a line, use the first-beat count N for the cycle's direction (`start_wr`=1 means write). Sampling opens on beat clock N+1, where beat clock 1 is the clock after the `start` edge.
- R4: Beats 2, 3 and 4 of a line (`start_line`=1) each use the follow-on count M for the direction. Each beat's clock 1 is the clock after the previous beat's acknowledge. Sampling for that beat opens on beat clock M+1.
- R5: While a beat's count is non-zero, all three termination inputs are ignored: `beat_done` and `cycle_done` stay low.
- R6: `sample_go` is high for exactly one clock per beat, on the clock that sampling opens.
- R7: On a single transfer, an acknowledge sampled after the hold-off raises `beat_done` and `cycle_done` together, with `cycle_status`=0 (normal).
- R8: A line raises `beat_done` on each of four acknowledged beats. `cycle_done` with status 0 is raised only on the fourth.
- R9: A sampled error ends the cycle at once with `cycle_status`=1. A sampled retry ends it at once with `cycle_status`=2. Error wins when both are present. No `beat_done` is raised on that clock.
- R10: `busy` is high from the clock after an accepted `start` through the clock of `cycle_done`, and low afterwards. A `start` seen while `busy` is high is ignored.
- R11: During and right after reset, `busy`, `sample_go`, `beat_done` and `cycle_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Hold-off enable, captured during reset |
| cfg_bus | input | 16 | Data bus, captured during reset |
| start | input | 1 | One-clock bus cycle start |
| start_wr | input | 1 | Direction of the starting cycle, 1 = write |
| start_line | input | 1 | 1 = four-beat line, 0 = single transfer |
| term_ack | input | 1 | Acknowledge termination, active high |
| term_err | input | 1 | Error termination, active high |
| term_retry | input | 1 | Retry termination, active high |
| sample_go | output | 1 | One-clock strobe, sampling opens |
| beat_done | output | 1 | Beat acknowledged |
| cycle_done | output | 1 | Cycle finished |
| cycle_status | output | 2 | Outcome on cycle_done: 0 normal, 1 error, 2 retry |
| busy | output | 1 | Cycle in progress |

## Verification
The hardest case to reach is a termination input that is already asserted during the masked clocks, on a beat of a line that uses the follow-on count. Termination arriving after the mask expires does not exercise this. The stimulus therefore holds acknowledge, error or retry high from the first clock of each beat, and moves the error or retry to a chosen later beat. Any early sampling then shows up as a premature beat or cycle end. The sweep repeats this over several captured bit patterns, both directions, both cycle kinds, and with the feature disabled. One pass also keeps `start` high with the opposite direction for the whole cycle, to show that a restart would be visible.

// File: rtl/ack_holdoff_pkg.sv
package ack_holdoff_pkg;

   // outcome reported with cycle_done
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_ERROR  = 2'd1,
      ST_RETRY  = 2'd2
   } cyc_status_e;

   // field slot i occupies bits [i*W +: W] of the captured word
   localparam int unsigned NUM_FIELDS = 4;
   localparam int unsigned FLD_WR_NEXT  = 0;
   localparam int unsigned FLD_WR_FIRST = 1;
   localparam int unsigned FLD_RD_NEXT  = 2;
   localparam int unsigned FLD_RD_FIRST = 3;

endpackage

// File: rtl/holdoff_cfg_latch.sv
module holdoff_cfg_latch #(
   parameter int unsigned CNT_W = 4,
   localparam int unsigned BUS_W = ack_holdoff_pkg::NUM_FIELDS * CNT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   input  logic [BUS_W-1:0] cfg_bus,
   output logic [BUS_W-1:0] counts
);
   import ack_holdoff_pkg::*;

   logic             en_q;
   logic [BUS_W-1:0] raw_q;

   // sampled every reset clock, so the last reset clock wins
   always_ff @(posedge clk) begin
      if (rst) begin
         en_q  <= cfg_en;
         raw_q <= cfg_bus;
      end
   end

   // per-field masking: a disabled feature reads as zero hold-off
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      assign counts[f*CNT_W +: CNT_W] = en_q ? raw_q[f*CNT_W +: CNT_W] : '0;
   end

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(counts)); // R1

endmodule

// File: rtl/holdoff_down_ctr.sv
module holdoff_down_ctr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_zero = (cnt_q == '0);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      !load && !cnt_zero |=> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/ack_holdoff_ctl.sv
module ack_holdoff_ctl #(
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned LINE_BEATS = 4,
   localparam int unsigned BUS_W     = ack_holdoff_pkg::NUM_FIELDS * CNT_W,
   localparam int unsigned IDX_W     = $clog2(LINE_BEATS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   input  logic [BUS_W-1:0] cfg_bus,
   input  logic             start,
   input  logic             start_wr,
   input  logic             start_line,
   input  logic             term_ack,
   input  logic             term_err,
   input  logic             term_retry,
   output logic             sample_go,
   output logic             beat_done,
   output logic             cycle_done,
   output logic [1:0]       cycle_status,
   output logic             busy
);
   import ack_holdoff_pkg::*;

   if (CNT_W < 1) begin : g_bad_width
      $error("CNT_W must be at least 1");
   end
   if (LINE_BEATS < 2 || (1 << IDX_W) != LINE_BEATS) begin : g_bad_beats
      $error("LINE_BEATS must be a power of two of at least 2");
   end

   logic [BUS_W-1:0] counts;
   logic             cnt_zero;
   logic             active_q, fresh_q, wr_q, line_q;
   logic [IDX_W-1:0] idx_q;
   logic             accept, sampling, hit_ack, hit_err, hit_rty;
   logic             last_beat, advance, load;
   logic [CNT_W-1:0] load_val;
   cyc_status_e      status;

   holdoff_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .cfg_en (cfg_en),
      .cfg_bus(cfg_bus),
      .counts (counts)
   );

   holdoff_down_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .load_val(load_val),
      .cnt_zero(cnt_zero)
   );

   assign accept    = start && !active_q;
   assign sampling  = active_q && cnt_zero;
   assign hit_err   = sampling && term_err;
   assign hit_rty   = sampling && term_retry && !term_err;
   assign hit_ack   = sampling && term_ack && !term_err && !term_retry;
   assign last_beat = !line_q || (idx_q == IDX_W'(LINE_BEATS - 1));
   assign advance   = hit_ack && !last_beat;
   assign load      = accept || advance;

   always_comb begin
      if (accept)
         load_val = start_wr ? counts[FLD_WR_FIRST*CNT_W +: CNT_W]
                             : counts[FLD_RD_FIRST*CNT_W +: CNT_W];
      else
         load_val = wr_q ? counts[FLD_WR_NEXT*CNT_W +: CNT_W]
                         : counts[FLD_RD_NEXT*CNT_W +: CNT_W];
   end

   always_comb begin
      if (hit_err)      status = ST_ERROR;
      else if (hit_rty) status = ST_RETRY;
      else              status = ST_NORMAL;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         fresh_q  <= 1'b0;
         wr_q     <= 1'b0;
         line_q   <= 1'b0;
         idx_q    <= '0;
      end else begin
         if (accept) begin
            active_q <= 1'b1;
            wr_q     <= start_wr;
            line_q   <= start_line;
            idx_q    <= '0;
         end else if (cycle_done) begin
            active_q <= 1'b0;
         end else if (advance) begin
            idx_q <= idx_q + 1'b1;
         end
         if (load)          fresh_q <= 1'b1;
         else if (sampling) fresh_q <= 1'b0;
      end
   end

   assign sample_go    = sampling && fresh_q;
   assign beat_done    = hit_ack;
   assign cycle_done   = hit_err || hit_rty || (hit_ack && last_beat);
   assign cycle_status = status;
   assign busy         = active_q;

   AST_HOLD_MASKS: assert property (@(posedge clk) disable iff (rst)
      busy && !cnt_zero |-> !beat_done && !cycle_done); // R5
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      sample_go && !beat_done |=> !sample_go); // R6
   AST_LINE_LAST: assert property (@(posedge clk) disable iff (rst)
      cycle_done && cycle_status == 2'd0 && line_q |-> idx_q == IDX_W'(LINE_BEATS - 1)); // R8
   AST_ABORT_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
      cycle_done && cycle_status != 2'd0 |-> !beat_done); // R9
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
      cycle_done |=> !busy); // R10
   AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy && !cycle_done |=> busy && $stable(wr_q)); // R10

endmodule

// File: tb/ack_holdoff_ctl_test.sv
module ack_holdoff_ctl_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_en = 1'b0;
   logic [15:0] cfg_bus = '0;
   logic        start = 1'b0, start_wr = 1'b0, start_line = 1'b0;
   logic        term_ack = 1'b0, term_err = 1'b0, term_retry = 1'b0;
   logic        sample_go, beat_done, cycle_done, busy;
   logic [1:0]  cycle_status;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic        cur_en;
   logic [15:0] cur_bus;

   always #2.5 clk = ~clk;

   ack_holdoff_ctl uut (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bus(cfg_bus),
      .start(start), .start_wr(start_wr), .start_line(start_line),
      .term_ack(term_ack), .term_err(term_err), .term_retry(term_retry),
      .sample_go(sample_go), .beat_done(beat_done), .cycle_done(cycle_done),
      .cycle_status(cycle_status), .busy(busy)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_cnt(input logic wr, input int beat);
      if (!cur_en) return 0;
      if (!wr) return (beat == 0) ? int'(cur_bus[15:12]) : int'(cur_bus[11:8]);
      return (beat == 0) ? int'(cur_bus[7:4]) : int'(cur_bus[3:0]);
   endfunction

   // R1 R2 R11: capture happens on the last reset clock, bus scrambled after
   task automatic do_reset(input logic en, input logic [15:0] word);
      @(negedge clk);
      rst = 1'b1; cfg_en = en; cfg_bus = word;
      cur_en = en; cur_bus = word;
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !sample_go && !beat_done && !cycle_done, "R11 idle in reset",
          {busy, sample_go, beat_done, cycle_done}, 0);
      rst = 1'b0; cfg_en = ~en; cfg_bus = ~word;
      @(negedge clk);
      #1;
      chk(!busy && !sample_go && !cycle_done, "R11 idle after reset",
          {busy, sample_go, cycle_done}, 0);
   endtask

   // kind: 0 all ack, 1 error, 2 retry, 3 error+retry, applied on beat kbeat
   task automatic run_cyc(input logic wr, input logic line, input int kind,
                          input int kbeat, input logic hold);
      int nb = line ? 4 : 1;
      logic fin = 1'b0;
      @(negedge clk);
      start = 1'b1; start_wr = wr; start_line = line;
      @(negedge clk);
      if (hold) start_wr = ~wr;
      else start = 1'b0;
      for (int b = 0; b < nb && !fin; b++) begin
         int n = exp_cnt(wr, b);
         logic abort = (kind != 0) && (b == kbeat);
         logic last  = abort || (b == nb - 1);
         term_ack   = 1'b1;
         term_err   = abort && (kind == 1 || kind == 3);
         term_retry = abort && (kind == 2 || kind == 3);
         for (int k = 1; k <= n + 1; k++) begin
            #1;
            chk(busy, "R10 busy in beat", busy, 1);
            chk(sample_go == (k == n + 1), (b == 0) ? "R3 R6 strobe timing" : "R4 R6 strobe timing",
                sample_go, (k == n + 1));
            if (k <= n) begin
               chk(!beat_done && !cycle_done, "R5 terminations masked",
                   {beat_done, cycle_done}, 0);
            end else begin
               int es = !abort ? 0 : (kind == 2 ? 2 : 1);
               chk(beat_done == !abort, abort ? "R9 no beat on abort" : "R8 beat acknowledged",
                   beat_done, !abort);
               chk(cycle_done == last, line ? "R8 line completion" : "R7 single completion",
                   cycle_done, last);
               if (last) begin
                  chk(cycle_status == 2'(es), abort ? "R9 abort status" : "R7 normal status",
                      cycle_status, es);
                  start = 1'b0;
                  fin = 1'b1;
               end
            end
            @(negedge clk);
         end
      end
      term_ack = 1'b0; term_err = 1'b0; term_retry = 1'b0;
      #1;
      chk(!busy && !sample_go, "R10 released after done", {busy, sample_go}, 0);
   endtask

   initial begin
      logic [15:0] pats [4];
      pats[0] = 16'h3120; pats[1] = 16'h0213; pats[2] = 16'h5A07; pats[3] = 16'hF1E2;
      for (int p = 0; p < 5; p++) begin
         if (p < 4) do_reset(1'b1, pats[p]);
         else       do_reset(1'b0, 16'hFFFF); // R2 disabled: zero hold-off
         for (int w = 0; w < 2; w++) begin
            for (int l = 0; l < 2; l++) begin
               run_cyc(w[0], l[0], 0, 0, 1'b0);
               run_cyc(w[0], l[0], 1, 0, 1'b0);
               run_cyc(w[0], l[0], 2, l ? 2 : 0, 1'b0);
               run_cyc(w[0], l[0], 3, l ? 3 : 0, 1'b0);
            end
         end
         // R10 start held high with the other direction must not restart
         run_cyc(1'b0, 1'b1, 0, 0, 1'b1);
         run_cyc(1'b1, 1'b0, 0, 0, 1'b1);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule